// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external controller read and write a small bank of 8-bit configuration registers over a three-wire serial link made of chip select, serial clock and one bidirectional data line. The chip-side core splits the data line into an input, an output and an output enable. All three serial inputs are brought into the core clock domain by synchronizers. Their edges are then found by comparing each sample with the one before. As a result, the serial clock must run well below the core clock.

Each transaction opens with a 16-bit command word. The command gives the direction, how many data bytes follow and where the access starts. Data bytes follow the command, and an internal address counter advances by one after each byte.

Before the first transaction the block runs in strap mode. In that mode, the levels on the serial clock and data pins choose the output coding and the output driver type. The first time chip select goes low, the block leaves strap mode for good and keeps the strap choices it last saw. One register, at address 8, is decoded into a reference-enable bit and a 3-bit full-scale select.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, strap mode is active, the data output enable is low, and every register reads 0x00.
- R2: In strap mode, `fmtTwosComp` follows the serial clock pin (high = two's complement, low = offset binary), and `lvdsSel` follows the data pin (high = LVDS DDR, low = CMOS).
- R3: The first low level on chip select sets `spiMode`. `spiMode` stays set until reset, and the two strap outputs then keep their last strap-mode values.
- R4: The command is 16 bits, sent MSB first and sampled on rising serial clock edges. Bit 15 is the direction (1 = read). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R5: Length codes 00, 01 and 10 give 1, 2 and 3 data bytes. Any later bytes in the same transaction have no effect.
- R6: Length code 11 transfers one byte per 8 clocks until chip select rises.
- R7: The access address starts at the command address and increases by one after each data byte.
- R8: A data byte cut short by chip select rising is discarded.
- R9: Read data is sent MSB first, with each bit changing after a falling serial clock edge. The output enable is high only during the data phase of a read.
- R10: At address 8, bits 7:4 read as zero and ignore writes. Bit 3 drives `refEnable` and bits 2:0 drive `fullScaleSel`.
- R11: Addresses at or above the bank size (16) read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; strap for output coding in strap mode |
| sdioIn | input | 1 | Data line input; strap for driver type in strap mode |
| sdioOut | output | 1 | Data line output value |
| sdioOe | output | 1 | Data line output enable |
| spiMode | output | 1 | High once serial control mode is entered |
| fmtTwosComp | output | 1 | Output coding: 1 two's complement, 0 offset binary |
| lvdsSel | output | 1 | Driver type: 1 LVDS DDR, 0 CMOS |
| refEnable | output | 1 | Internal reference enable from register 8 |
| fullScaleSel | output | 3 | Full-scale select from register 8 |

## Verification
The hardest case to reach is a chip select that rises partway through a byte, during a transaction whose length code is still running or already used up. The bench's transfer task takes a byte count and a count of trailing bits. It can therefore stop after any number of whole bytes plus a partial one, or keep clocking past the coded length, and it then reads the neighbouring registers back. Register contents are tracked in a bench model that applies the length limit, the address-8 mask and the unmapped range arithmetically. A full 16-byte streaming write followed by streaming and single reads sweeps the whole bank.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int CMD_W  = 16;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } regCmd_t;
endpackage

// File: rtl/spi_cfg_ctl.sv
module spi_cfg_ctl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rdData,
  output regCmd_t           cmd,
  output logic              sdo,
  output logic              sdoOe,
  output logic              modeSpi,
  output logic              fmtTwos,
  output logic              outLvds
);
  typedef enum logic [1:0] {PH_IDLE, PH_INSTR, PH_DATA, PH_DONE} phase_t;

  logic [1:0] csS, sclkS, sdiS;
  logic       sclkPrev;
  phase_t     phase;
  logic [3:0] bitCnt;
  logic [CMD_W-2:0] shiftIn;
  logic       isRead;
  logic [1:0] lenCode, bytesDone;
  logic [ADDR_W-1:0] addrCnt;
  logic [DATA_W-1:0] shiftOut;

  logic csActive, sclkRise, sclkFall, byteEnd;
  logic [CMD_W-1:0] instrWord;

  assign csActive  = ~csS[1];
  assign sclkRise  = sclkS[1] & ~sclkPrev;
  assign sclkFall  = ~sclkS[1] & sclkPrev;
  assign instrWord = {shiftIn, sdiS[1]};
  assign byteEnd   = csActive && (phase == PH_DATA) && sclkRise && (bitCnt[2:0] == 3'd7);

  always_comb begin
    cmd.wrStb = byteEnd && !isRead;
    cmd.addr  = addrCnt;
    cmd.wdata = {shiftIn[DATA_W-2:0], sdiS[1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS <= 2'b11; sclkS <= '0; sdiS <= '0; sclkPrev <= 1'b0;
      phase <= PH_IDLE; bitCnt <= '0; shiftIn <= '0; isRead <= 1'b0;
      lenCode <= '0; bytesDone <= '0; addrCnt <= '0; shiftOut <= '0;
      sdo <= 1'b0; sdoOe <= 1'b0;
      modeSpi <= 1'b0; fmtTwos <= 1'b0; outLvds <= 1'b0;
    end else begin
      csS      <= {csS[0], csN};
      sclkS    <= {sclkS[0], sclk};
      sdiS     <= {sdiS[0], sdi};
      sclkPrev <= sclkS[1];
      if (!modeSpi) begin
        fmtTwos <= sclkS[1];
        outLvds <= sdiS[1];
        if (csActive) modeSpi <= 1'b1;
      end
      if (!csActive) begin
        phase <= PH_IDLE;
        sdoOe <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            phase     <= PH_INSTR;
            bitCnt    <= '0;
            bytesDone <= '0;
          end
          PH_INSTR: if (sclkRise) begin
            shiftIn <= instrWord[CMD_W-2:0];
            bitCnt  <= bitCnt + 4'd1;
            if (bitCnt == 4'd15) begin
              isRead  <= instrWord[15];
              lenCode <= instrWord[14:13];
              addrCnt <= instrWord[ADDR_W-1:0];
              phase   <= PH_DATA;
            end
          end
          PH_DATA: begin
            if (sclkRise) begin
              shiftIn <= instrWord[CMD_W-2:0];
              bitCnt  <= {1'b0, bitCnt[2:0] + 3'd1};
            end
            if (byteEnd) begin
              addrCnt   <= addrCnt + 1'b1;
              bytesDone <= bytesDone + 2'd1;
              if (lenCode != 2'b11 && bytesDone == lenCode) begin
                phase <= PH_DONE;
                sdoOe <= 1'b0;
              end
            end
            if (sclkFall && isRead) begin
              sdoOe <= 1'b1;
              if (bitCnt[2:0] == 3'd0) begin
                sdo      <= rdData[DATA_W-1];
                shiftOut <= {rdData[DATA_W-2:0], 1'b0};
              end else begin
                sdo      <= shiftOut[DATA_W-1];
                shiftOut <= {shiftOut[DATA_W-2:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: serial mode, once entered, persists
  a_r3_mode_sticky: assert property (@(posedge clk) disable iff (!rstN)
    modeSpi |=> modeSpi);
  // R3: strap outputs frozen in serial mode
  a_r3_strap_frozen: assert property (@(posedge clk) disable iff (!rstN)
    modeSpi |=> ($stable(fmtTwos) && $stable(outLvds)));
  // R9: data line driven only for reads, never during the command
  a_r9_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> (isRead && phase != PH_INSTR));
  // R5: byte counter never passes the coded length
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && lenCode != 2'b11) |-> (bytesDone <= lenCode));
  // R7: each written byte advances the address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |=> (addrCnt == $past(addrCnt) + 1'b1));
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REF_ADDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCmd_t           cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              refEnable,
  output logic [2:0]        fullScaleSel
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [DATA_W-1:0] REF_MASK = 8'h0F;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic inRange;
  logic [IDX_W-1:0] idx;

  assign inRange = (cmd.addr < ADDR_W'(NUM_REGS));
  assign idx     = cmd.addr[IDX_W-1:0];
  assign rdData  = inRange ? regs[idx] : '0;
  assign refEnable    = regs[REF_ADDR][3];
  assign fullScaleSel = regs[REF_ADDR][2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (cmd.wrStb && inRange) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (idx == IDX_W'(i))
          regs[i] <= (i == REF_ADDR) ? (cmd.wdata & REF_MASK) : cmd.wdata;
      end
    end
  end

  // R11: writes outside the bank leave every register unchanged
  a_r11_unmapped_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && !inRange) |=> $stable(regs));
  // R10: upper nibble of the reference register never becomes set
  a_r10_ref_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |=> (regs[REF_ADDR][7:4] == 4'h0));
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REF_ADDR = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdioIn,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic       spiMode,
  output logic       fmtTwosComp,
  output logic       lvdsSel,
  output logic       refEnable,
  output logic [2:0] fullScaleSel
);
  regCmd_t           cmd;
  logic [DATA_W-1:0] rdData;

  spi_cfg_ctl u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdioIn),
    .rdData(rdData), .cmd(cmd), .sdo(sdioOut), .sdoOe(sdioOe),
    .modeSpi(spiMode), .fmtTwos(fmtTwosComp), .outLvds(lvdsSel)
  );

  spi_cfg_regs #(.NUM_REGS(NUM_REGS), .REF_ADDR(REF_ADDR)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdData(rdData),
    .refEnable(refEnable), .fullScaleSel(fullScaleSel)
  );
endmodule

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
  localparam int HALF = 6;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdioIn;
  logic sdioOut, sdioOe, spiMode, fmtTwosComp, lvdsSel, refEnable;
  logic [2:0] fullScaleSel;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NREG];
  logic [7:0] txBuf [20];
  logic [7:0] rxBuf [20];
  int instrOe, dataOe;

  always #2 clk = ~clk;

  spi_cfg_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .spiMode(spiMode),
    .fmtTwosComp(fmtTwosComp), .lvdsSel(lvdsSel),
    .refEnable(refEnable), .fullScaleSel(fullScaleSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic got, output logic oe);
    sclk = 1'b0;
    sdioIn = b;
    waitClk(HALF);
    got = sdioOut;
    oe = sdioOe;
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  // whole bytes from txBuf, then tailBits partial bits of ones
  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                      input int nbytes, input int tailBits);
    logic [15:0] instr;
    logic got, oe;
    instr = {rd, len, addr};
    instrOe = 0; dataOe = 0;
    sclk = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 15; i >= 0; i--) begin
      sendBit(instr[i], got, oe);
      if (oe) instrOe++;
    end
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) begin
        sendBit(txBuf[k][i], got, oe);
        rxBuf[k][i] = got;
        if (oe) dataOe++;
      end
    end
    for (int i = 0; i < tailBits; i++) sendBit(1'b1, got, oe);
    sclk = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  function automatic int effBytes(input logic [1:0] len, input int n);
    if (len == 2'b11) return n;
    return (n < int'(len) + 1) ? n : int'(len) + 1;
  endfunction

  task automatic modelWrite(input logic [1:0] len, input int addr, input int n);
    for (int j = 0; j < effBytes(len, n); j++) begin
      if (addr + j < NREG)
        model[addr + j] = (addr + j == 8) ? (txBuf[j] & 8'h0F) : txBuf[j];
    end
  endtask

  function automatic logic [7:0] expRd(input int a);
    return (a < NREG) ? model[a] : 8'h00;
  endfunction

  task automatic wrBytes(input logic [1:0] len, input int addr, input int n, input int tail);
    xfer(1'b0, len, 13'(addr), n, tail);
    modelWrite(len, addr, n);
  endtask

  task automatic readCheck(input string req, input int addr);
    txBuf[0] = 8'h00;
    xfer(1'b1, 2'b00, 13'(addr), 1, 0);
    check(req, {24'h0, rxBuf[0]}, {24'h0, expRd(addr)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdioIn = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    waitClk(5);
    // R1 reset state
    check("R1 spiMode", {31'h0, spiMode}, 32'h0);
    check("R1 sdioOe", {31'h0, sdioOe}, 32'h0);
    rstN = 1'b1;
    waitClk(3);

    // R2 all four strap combinations
    for (int c = 0; c < 4; c++) begin
      sclk = c[0]; sdioIn = c[1];
      waitClk(6);
      check("R2 fmtTwosComp", {31'h0, fmtTwosComp}, {31'h0, c[0]});
      check("R2 lvdsSel", {31'h0, lvdsSel}, {31'h0, c[1]});
    end

    // R3 enter serial mode with straps two's complement, CMOS
    sclk = 1'b1; sdioIn = 1'b0;
    waitClk(6);
    csN = 1'b0;
    waitClk(6);
    check("R3 spiMode set", {31'h0, spiMode}, 32'h1);
    sclk = 1'b0;
    waitClk(3);
    csN = 1'b1; sdioIn = 1'b1;
    waitClk(8);
    check("R3 spiMode held", {31'h0, spiMode}, 32'h1);
    check("R3 fmt frozen", {31'h0, fmtTwosComp}, 32'h1);
    check("R3 lvds frozen", {31'h0, lvdsSel}, 32'h0);

    // R1 all registers read zero after reset
    for (int a = 0; a < NREG; a++) readCheck("R1 reset value", a);

    // R6 R7 streaming write across the whole bank
    for (int k = 0; k < NREG; k++) txBuf[k] = 8'((k * 37 + 5) ^ (k << 4));
    wrBytes(2'b11, 0, NREG, 0);
    // R4 single reads of each register
    for (int a = 0; a < NREG; a++) readCheck("R4 single read", a);
    // R6 R9 streaming read of the whole bank
    xfer(1'b1, 2'b11, 13'd0, NREG, 0);
    for (int a = 0; a < NREG; a++)
      check("R6 stream read", {24'h0, rxBuf[a]}, {24'h0, expRd(a)});
    check("R9 oe in read data", dataOe, NREG * 8);
    check("R9 oe not in command", instrOe, 0);
    check("R9 oe released after", {31'h0, sdioOe}, 32'h0);

    // R5 each short length code, with extra bytes clocked
    txBuf[0] = 8'hA1; txBuf[1] = 8'hB2; txBuf[2] = 8'hC3; txBuf[3] = 8'hD4;
    wrBytes(2'b00, 2, 3, 0);
    for (int a = 2; a < 5; a++) readCheck("R5 len code 00", a);
    wrBytes(2'b01, 5, 4, 0);
    for (int a = 5; a < 9; a++) readCheck("R5 len code 01", a);
    wrBytes(2'b10, 10, 4, 0);
    for (int a = 10; a < 14; a++) readCheck("R5 len code 10", a);
    // R5 read limited to one byte: line released for the second
    xfer(1'b1, 2'b00, 13'd3, 2, 0);
    check("R5 read len 00 oe bits", dataOe, 8);

    // R8 partial bytes discarded
    txBuf[0] = 8'h5A; txBuf[1] = 8'h66;
    wrBytes(2'b00, 6, 0, 5);
    readCheck("R8 partial first byte", 6);
    wrBytes(2'b11, 12, 1, 3);
    readCheck("R8 whole byte kept", 12);
    readCheck("R8 partial second byte", 13);

    // R10 reference register decode and mask
    txBuf[0] = 8'hFF;
    wrBytes(2'b00, 8, 1, 0);
    readCheck("R10 masked read FF", 8);
    check("R10 refEnable", {31'h0, refEnable}, 32'h1);
    check("R10 fullScaleSel", {29'h0, fullScaleSel}, 32'h7);
    txBuf[0] = 8'h35;
    wrBytes(2'b00, 8, 1, 0);
    readCheck("R10 masked read 35", 8);
    check("R10 refEnable off", {31'h0, refEnable}, 32'h0);
    check("R10 fullScaleSel 5", {29'h0, fullScaleSel}, 32'h5);

    // R11 unmapped space
    txBuf[0] = 8'h77;
    wrBytes(2'b00, 13'h1234, 1, 0);
    readCheck("R11 unmapped read", 13'h1234);
    txBuf[0] = 8'h00; txBuf[1] = 8'h00;
    xfer(1'b1, 2'b01, 13'd15, 2, 0);
    check("R11 last mapped", {24'h0, rxBuf[0]}, {24'h0, expRd(15)});
    check("R11 first unmapped", {24'h0, rxBuf[1]}, 32'h0);
    for (int a = 0; a < NREG; a++) readCheck("R11 bank intact", a);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule